// File: doc/BRIEF.md
# Fracturable Unsigned Integer Multiplier

This block multiplies two 36-bit unsigned operands and returns a 72-bit product. A two-bit mode input, held steady by the surrounding logic, splits the same pins into one wide multiplier, two 18-bit multipliers or four 9-bit multipliers. In each split mode every operand slice is multiplied only by the matching slice of the other operand. The narrow products are packed side by side on the output bus, with lane 0 in the least significant bits.

Internally the operands are cut into a grid of 9-bit tiles. Each tile forms one partial product. The mode decides which tiles take part. The enabled partial products are then shifted into place and summed. Because each lane's product fits its own output field, no carry leaves a lane. The path from operands to product has no register and no clock.

Top module: `fmul_frac`

## Requirements
- R1: The product is a purely combinational function of `op_a`, `op_b` and `mode`. It settles without any clock edge, and all-zero operands give an all-zero product.
- R2: With `mode` = 2'b00 the product is the full 72-bit unsigned product `op_a * op_b`.
- R3: With `mode` = 2'b01, lane 0 takes operand bits [17:0] and lane 1 takes bits [35:18]. Their 36-bit products appear on product bits [35:0] and [71:36] respectively.
- R4: With `mode` = 2'b10, lane k (k = 0..3) takes operand bits [9k+8:9k]. Its 18-bit product appears on product bits [18k+17:18k].
- R5: In each split mode, lanes are packed in ascending order, so a lower lane index always sits in lower product bits.
- R6: With `mode` = 2'b11 (reserved), the product is all zeros for any operands.
- R7: In a split mode, no carry and no partial product from one lane reaches another lane's product bits, even when every operand bit is one.
- R8: Operands are treated as unsigned. All-ones operands in full mode give (2^36-1)^2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode | input | 2 | Fracture select: 00 one wide product, 01 two half lanes, 10 four quarter lanes, 11 zero output |
| op_a | input | 36 | Multiplicand, divided into lanes according to `mode` |
| op_b | input | 36 | Multiplier, divided into lanes according to `mode` |
| prod | output | 72 | Packed lane products, lane 0 at the least significant end |

## Verification
The bench builds the block with its default parameters: 9-bit tiles and four tiles per operand. This gives the 36-bit operand and 72-bit product described above, and makes every lane boundary of all three split levels observable at the pins. Random operands in every mode are compared against a model that multiplies each slice on its own. Directed all-ones, all-zero, identity and lane-tagged patterns test carry containment at the lane edges and the packing order.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  typedef enum logic [1:0] {
    MODE_FULL    = 2'b00,
    MODE_HALF    = 2'b01,
    MODE_QUARTER = 2'b10,
    MODE_RSVD    = 2'b11
  } fmul_mode_e;
endpackage

// File: rtl/fmul_tile.sv
// One partial-product tile; operands are forced to zero when the tile is idle.
module fmul_tile #(
  parameter int W = 9
) (
  input  logic           en,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  logic [W-1:0] ga, gb;

  assign ga = en ? a : '0;
  assign gb = en ? b : '0;
  assign p  = {{W{1'b0}}, ga} * {{W{1'b0}}, gb};
endmodule

// File: rtl/fmul_tile_mask.sv
// Decides which tiles of the grid belong to a lane under the current mode.
module fmul_tile_mask #(
  parameter int LANES = 4
) (
  input  fmul_pkg::fmul_mode_e mode,
  output logic [LANES*LANES-1:0] tile_en
);
  import fmul_pkg::*;

  localparam int HALF_G = LANES / 2;
  localparam int QUAR_G = LANES / 4;

  for (genvar i = 0; i < LANES; i++) begin : g_row
    for (genvar j = 0; j < LANES; j++) begin : g_col
      localparam bit IN_HALF = (i / HALF_G) == (j / HALF_G);
      localparam bit IN_QUAR = (i / QUAR_G) == (j / QUAR_G);
      always_comb begin
        unique case (mode)
          MODE_FULL:    tile_en[i*LANES+j] = 1'b1;
          MODE_HALF:    tile_en[i*LANES+j] = IN_HALF;
          MODE_QUARTER: tile_en[i*LANES+j] = IN_QUAR;
          default:      tile_en[i*LANES+j] = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/fmul_reduce.sv
// Shifts every tile product to weight LANE_W*(i+j) and sums them.
module fmul_reduce #(
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic [LANES*LANES*2*LANE_W-1:0] tile_p,
  output logic [2*LANE_W*LANES-1:0]        sum
);
  localparam int TW     = 2 * LANE_W;
  localparam int PROD_W = 2 * LANE_W * LANES;

  always_comb begin
    sum = '0;
    for (int t = 0; t < LANES * LANES; t++) begin
      sum = sum + (PROD_W'(tile_p[t*TW +: TW]) << (LANE_W * (t / LANES + t % LANES)));
    end
  end
endmodule

// File: rtl/fmul_frac.sv
module fmul_frac #(
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic [1:0]                  mode,
  input  logic [LANE_W*LANES-1:0]     op_a,
  input  logic [LANE_W*LANES-1:0]     op_b,
  output logic [2*LANE_W*LANES-1:0]   prod
);
  import fmul_pkg::*;

  localparam int TILES = LANES * LANES;
  localparam int TW    = 2 * LANE_W;

  fmul_mode_e             mode_e;
  logic [TILES-1:0]       tile_en;
  logic [TILES*TW-1:0]    tile_p;

  assign mode_e = fmul_mode_e'(mode);

  fmul_tile_mask #(.LANES(LANES)) u_mask (
    .mode    (mode_e),
    .tile_en (tile_en)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_arow
    for (genvar j = 0; j < LANES; j++) begin : g_bcol
      fmul_tile #(.W(LANE_W)) u_tile (
        .en (tile_en[i*LANES+j]),
        .a  (op_a[i*LANE_W +: LANE_W]),
        .b  (op_b[j*LANE_W +: LANE_W]),
        .p  (tile_p[(i*LANES+j)*TW +: TW])
      );
    end
  end

  fmul_reduce #(.LANE_W(LANE_W), .LANES(LANES)) u_reduce (
    .tile_p (tile_p),
    .sum    (prod)
  );
endmodule

// File: rtl/fmul_frac_chk.sv
module fmul_frac_chk #(
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input logic [1:0]                mode,
  input logic [LANE_W*LANES-1:0]   op_a,
  input logic [LANE_W*LANES-1:0]   op_b,
  input logic [2*LANE_W*LANES-1:0] prod
);
  localparam int OP_W = LANE_W * LANES;
  localparam int HW   = 2 * LANE_W;

  always_comb begin
    p_rsvd_zero_r6: assert (mode != 2'b11 || prod == '0);
    p_full_ident_r2: assert (!(mode == 2'b00 && op_b == OP_W'(1)) || prod == {{OP_W{1'b0}}, op_a});
    p_zero_in_r1: assert (!(op_a == '0) || prod == '0);
  end

  for (genvar k = 0; k < LANES; k++) begin : g_quar
    always_comb begin
      p_quar_isolate_r7: assert (!(mode == 2'b10 && op_b[k*LANE_W +: LANE_W] == LANE_W'(1))
                                 || prod[k*2*LANE_W +: 2*LANE_W] == {{LANE_W{1'b0}}, op_a[k*LANE_W +: LANE_W]});
      p_quar_zero_r4: assert (!(mode == 2'b10 && op_a[k*LANE_W +: LANE_W] == '0)
                              || prod[k*2*LANE_W +: 2*LANE_W] == '0);
    end
  end

  for (genvar k = 0; k < LANES / 2; k++) begin : g_half
    always_comb begin
      p_half_isolate_r3: assert (!(mode == 2'b01 && op_b[k*HW +: HW] == HW'(1))
                                 || prod[k*2*HW +: 2*HW] == {{HW{1'b0}}, op_a[k*HW +: HW]});
    end
  end
endmodule

bind fmul_frac fmul_frac_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .mode (mode),
  .op_a (op_a),
  .op_b (op_b),
  .prod (prod)
);

// File: tb/fmul_frac_bench.sv
module fmul_frac_bench;
  logic        clk = 1'b0;
  logic [1:0]  mode;
  logic [35:0] op_a, op_b;
  logic [71:0] prod;
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  fmul_frac u_fmul_frac (.mode(mode), .op_a(op_a), .op_b(op_b), .prod(prod));

  function automatic logic [71:0] model(input logic [1:0] m, input logic [35:0] a, input logic [35:0] b);
    logic [71:0] r = '0;
    case (m)
      2'b00: r = {36'd0, a} * {36'd0, b};
      2'b01: for (int k = 0; k < 2; k++) begin
        logic [35:0] lp = {18'd0, a[k*18 +: 18]} * {18'd0, b[k*18 +: 18]};
        r[k*36 +: 36] = lp;
      end
      2'b10: for (int k = 0; k < 4; k++) begin
        logic [17:0] lp = {9'd0, a[k*9 +: 9]} * {9'd0, b[k*9 +: 9]};
        r[k*18 +: 18] = lp;
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic apply_check(input string req, input logic [1:0] m, input logic [35:0] a,
                             input logic [35:0] b, input logic [71:0] exp);
    @(negedge clk);
    mode = m; op_a = a; op_b = b;
    #2;
    n_chk++;
    if (prod !== exp) begin
      n_bad++;
      $display("FAIL %s mode=%0d a=%h b=%h actual=%h expected=%h", req, m, a, b, prod, exp);
    end
  endtask

  function automatic logic [35:0] rnd36();
    return {$urandom(), $urandom()} & 64'hF_FFFF_FFFF;
  endfunction

  initial begin
    logic [35:0] a, b;
    void'($urandom(32'h5EED_0042));
    mode = 2'b00; op_a = '0; op_b = '0;
    // R1: zero operands, no clock needed for the result
    #3;
    n_chk++;
    if (prod !== 72'd0) begin
      n_bad++;
      $display("FAIL R1 idle actual=%h expected=%h", prod, 72'd0);
    end
    // R1: settles mid-cycle without a clock edge
    @(posedge clk); #2;
    op_a = 36'd7; op_b = 36'd6; #1;
    n_chk++;
    if (prod !== 72'd42) begin
      n_bad++;
      $display("FAIL R1 comb actual=%h expected=%h", prod, 72'd42);
    end
    // R8: unsigned all-ones full product
    apply_check("R8", 2'b00, {36{1'b1}}, {36{1'b1}}, ({36'd0, {36{1'b1}}}) * ({36'd0, {36{1'b1}}}));
    // R7: all-ones in split modes stay inside lanes
    apply_check("R7", 2'b01, {36{1'b1}}, {36{1'b1}}, {2{36'hF_FFF8_0001}});
    apply_check("R7", 2'b10, {36{1'b1}}, {36{1'b1}}, {4{18'h3_FC01}});
    // R5: lane-tagged packing order
    apply_check("R5", 2'b10, {9'd4, 9'd3, 9'd2, 9'd1}, {4{9'd1}}, {18'd4, 18'd3, 18'd2, 18'd1});
    apply_check("R5", 2'b01, {18'd9, 18'd5}, {18'd1, 18'd1}, {36'd9, 36'd5});
    // R3: upper lane only, lower lane must stay zero
    apply_check("R3", 2'b01, {18'h3_FFFF, 18'd0}, {18'd2, 18'h3_FFFF}, {36'h7_FFFE, 36'd0});
    // R6: reserved code with busy operands
    apply_check("R6", 2'b11, {36{1'b1}}, {36{1'b1}}, 72'd0);
    // R2: full-mode identity crossing lane edges
    apply_check("R2", 2'b00, 36'hA_BCDE_F012, 36'd1, 72'hA_BCDE_F012);
    for (int n = 0; n < 150; n++) begin
      a = rnd36(); b = rnd36();
      apply_check("R2", 2'b00, a, b, model(2'b00, a, b));
      a = rnd36(); b = rnd36();
      apply_check("R3", 2'b01, a, b, model(2'b01, a, b));
      a = rnd36(); b = rnd36();
      apply_check("R4", 2'b10, a, b, model(2'b10, a, b));
    end
    for (int n = 0; n < 20; n++) begin
      a = rnd36(); b = rnd36();
      apply_check("R6", 2'b11, a, b, 72'd0);
    end
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule